// File: doc/BRIEF.md
# Two-Level Control Word Expander

This block turns a narrow per-cycle selector into the full set of wide ALU control words for an array of ALUs. It keeps two levels of configuration storage. The first level is a bank of combination lines, and each line names one stored instruction slot for every ALU. The second level is one bank of instruction slots per ALU, and each slot holds a complete control word. Every cycle the sequencer presents a line number. One cycle later the block drives the control word of every ALU, each taken from the slot that the chosen line names for that ALU.

All storage is loaded before a run through a 16-bit load port. The port takes an address, a write strobe and a data word. The address top bits pick a region, either the line bank or one ALU's slot bank. A slot is wider than the bus, so it is built from three bus words. The first two words are held in a staging buffer, and the third word commits the whole slot at once. While the run input is high, loads are refused and a sticky error flag is raised. The same line-and-slot structure could also drive register-file addressing, but this block produces only the ALU control words.

Top module: `cfgx_ctrl_expander`

## Requirements
- R1: After reset, `ctrl_words` and `load_err` are zero and every stored line and slot is zero, so every selector value yields an all-zero output.
- R2: One clock edge after `sel` is presented, bits `[37k+36:37k]` of `ctrl_words` equal slot `L[3k+2:3k]` of ALU k's bank, where L is line `sel`.
- R3: A load with region 0 (`ld_addr[9:7]`=0) and `run` low stores `ld_data[14:0]` into line `ld_addr[4:0]`. Bit 15 of the data is ignored. Field k of a line, bits `[3k+2:3k]`, is ALU k's slot index.
- R4: A slot of ALU k is loaded through region k+1 with slot number `ld_addr[4:2]` and word number `ld_addr[1:0]`. Word 0 supplies bits 15:0, word 1 supplies bits 31:16, and word 2's bits 4:0 supply bits 36:32. The upper 11 bits of word 2 are ignored.
- R5: Words 0 and 1 do not change the stored slot. The slot changes only when word 2 is written.
- R6: Each ALU's slot bank is written and read independently. A load into region k+1 changes no other ALU's words.
- R7: A load strobe while `run` is high changes no stored line or slot and sets `load_err` on the next edge.
- R8: `load_err` stays high until reset, even after `run` falls and legal loads follow.
- R9: Loads to regions 6 and 7, and loads with word number 3, have no effect on stored state or on `load_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High while the array executes; blocks loads |
| sel | input | 5 | Line number from the sequencer |
| ld_we | input | 1 | Load write strobe |
| ld_addr | input | 10 | Load address: region [9:7], offset [6:0] |
| ld_data | input | 16 | Load data word |
| ctrl_words | output | 185 | Registered control words, ALU k at [37k+36:37k] |
| load_err | output | 1 | Sticky flag for a load attempted while running |

## Verification
A load strobe is sampled on one edge and updates storage on that same edge. The selector passes through both read levels combinationally and is registered on the following edge, so `ctrl_words` is due one edge after `sel` is set. The bench drives inputs on the falling edge and samples a full period later, on the next falling edge, which lands after exactly that one register. `load_err` is due on the edge that samples a refused strobe, so the bench reads it at the falling edge after that strobe.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int unsigned DEF_ALUS   = 5;
  localparam int unsigned DEF_CW     = 37;
  localparam int unsigned DEF_SLOTS  = 8;
  localparam int unsigned DEF_LINES  = 32;
  localparam int unsigned DEF_BUS_W  = 16;
  localparam int unsigned DEF_REG_W  = 3;
  localparam int unsigned DEF_OFF_W  = 7;

  // region code of the line bank; ALU k uses LINE_REGION + 1 + k
  localparam int unsigned LINE_REGION = 0;
endpackage

// File: rtl/cfgx_bank.sv
module cfgx_bank #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 37,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cfgx_load_ctl.sv
module cfgx_load_ctl #(
  parameter int unsigned NUM_ALU = 5,
  parameter int unsigned CW      = 37,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned LINES   = 32,
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned REG_W   = 3,
  parameter int unsigned OFF_W   = 7,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned SEL_W  = $clog2(LINES),
  localparam int unsigned LINE_W = NUM_ALU * IDX_W,
  localparam int unsigned ADDR_W = REG_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               ld_we,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [BUS_W-1:0]   ld_data,
  output logic               line_we,
  output logic [SEL_W-1:0]   line_waddr,
  output logic [LINE_W-1:0]  line_wdata,
  output logic [NUM_ALU-1:0] slot_we,
  output logic [IDX_W-1:0]   slot_waddr,
  output logic [CW-1:0]      slot_wdata,
  output logic               load_err
);
  import cfgx_pkg::*;

  localparam int unsigned WORDS  = (CW + BUS_W - 1) / BUS_W;
  localparam int unsigned WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned STG_W  = (WORDS - 1) * BUS_W;
  localparam int unsigned LAST_W = CW - STG_W;

  logic [REG_W-1:0]  region;
  logic [OFF_W-1:0]  offset;
  logic [WSEL_W-1:0] word;
  logic              accept;
  logic              alu_region;
  logic              commit;
  logic [STG_W-1:0]  stage;

  assign region     = ld_addr[ADDR_W-1 -: REG_W];
  assign offset     = ld_addr[OFF_W-1:0];
  assign word       = offset[WSEL_W-1:0];
  assign accept     = ld_we && !run;
  assign alu_region = (region > REG_W'(LINE_REGION)) &&
                      (region <= REG_W'(LINE_REGION + NUM_ALU));
  assign commit     = accept && alu_region && (word == WSEL_W'(WORDS - 1));

  assign line_we    = accept && (region == REG_W'(LINE_REGION));
  assign line_waddr = offset[SEL_W-1:0];
  assign line_wdata = ld_data[LINE_W-1:0];

  assign slot_waddr = offset[WSEL_W +: IDX_W];
  assign slot_wdata = {ld_data[LAST_W-1:0], stage};

  for (genvar k = 0; k < NUM_ALU; k++) begin : g_slot_we
    assign slot_we[k] = commit && (region == REG_W'(LINE_REGION + 1 + k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= '0;
      load_err <= 1'b0;
    end else begin
      if (ld_we && run) load_err <= 1'b1;
      if (accept && alu_region && (word < WSEL_W'(WORDS - 1)))
        stage[word*BUS_W +: BUS_W] <= ld_data;
    end
  end
endmodule

// File: rtl/cfgx_ctrl_expander.sv
module cfgx_ctrl_expander #(
  parameter int unsigned NUM_ALU = cfgx_pkg::DEF_ALUS,
  parameter int unsigned CW      = cfgx_pkg::DEF_CW,
  parameter int unsigned SLOTS   = cfgx_pkg::DEF_SLOTS,
  parameter int unsigned LINES   = cfgx_pkg::DEF_LINES,
  parameter int unsigned BUS_W   = cfgx_pkg::DEF_BUS_W,
  parameter int unsigned REG_W   = cfgx_pkg::DEF_REG_W,
  parameter int unsigned OFF_W   = cfgx_pkg::DEF_OFF_W,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned SEL_W  = $clog2(LINES),
  localparam int unsigned LINE_W = NUM_ALU * IDX_W,
  localparam int unsigned ADDR_W = REG_W + OFF_W,
  localparam int unsigned OUT_W  = NUM_ALU * CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [SEL_W-1:0]  sel,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BUS_W-1:0]  ld_data,
  output logic [OUT_W-1:0]  ctrl_words,
  output logic              load_err
);
  logic               line_we;
  logic [SEL_W-1:0]   line_waddr;
  logic [LINE_W-1:0]  line_wdata;
  logic [NUM_ALU-1:0] slot_we;
  logic [IDX_W-1:0]   slot_waddr;
  logic [CW-1:0]      slot_wdata;
  logic [LINE_W-1:0]  line_rd;
  logic [CW-1:0]      alu_word [NUM_ALU];

  cfgx_load_ctl #(
    .NUM_ALU(NUM_ALU), .CW(CW), .SLOTS(SLOTS), .LINES(LINES),
    .BUS_W(BUS_W), .REG_W(REG_W), .OFF_W(OFF_W)
  ) u_load (
    .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .line_we(line_we), .line_waddr(line_waddr),
    .line_wdata(line_wdata), .slot_we(slot_we), .slot_waddr(slot_waddr),
    .slot_wdata(slot_wdata), .load_err(load_err)
  );

  cfgx_bank #(.DEPTH(LINES), .WIDTH(LINE_W)) u_lines (
    .clk(clk), .rst(rst), .we(line_we), .waddr(line_waddr),
    .wdata(line_wdata), .raddr(sel), .rdata(line_rd)
  );

  for (genvar k = 0; k < NUM_ALU; k++) begin : g_alu
    cfgx_bank #(.DEPTH(SLOTS), .WIDTH(CW)) u_slots (
      .clk(clk), .rst(rst), .we(slot_we[k]), .waddr(slot_waddr),
      .wdata(slot_wdata), .raddr(line_rd[k*IDX_W +: IDX_W]),
      .rdata(alu_word[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_words <= '0;
    end else begin
      for (int k = 0; k < NUM_ALU; k++) ctrl_words[k*CW +: CW] <= alu_word[k];
    end
  end
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int unsigned NUM_ALU = 5,
  parameter int unsigned OUT_W   = 185
) (
  input logic               clk,
  input logic               rst,
  input logic               run,
  input logic               ld_we,
  input logic               load_err,
  input logic               line_we,
  input logic [NUM_ALU-1:0] slot_we,
  input logic [OUT_W-1:0]   ctrl_words
);
  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_words == '0 && !load_err));

  // R7
  run_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (!line_we && slot_we == '0));

  // R7
  run_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_we && run) |=> load_err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    load_err |=> load_err);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(load_err) |-> $past(ld_we && run));

  // R6
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({line_we, slot_we}));
endmodule

bind cfgx_ctrl_expander cfgx_chk #(.NUM_ALU(NUM_ALU), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .ld_we(ld_we), .load_err(load_err),
  .line_we(line_we), .slot_we(slot_we), .ctrl_words(ctrl_words)
);

// File: tb/test_cfgx_ctrl_expander.sv
module test_cfgx_ctrl_expander;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 5;
  localparam int CW = 37;
  localparam int OW = NA * CW;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic [4:0]    sel = '0;
  logic          ld_we = 1'b0;
  logic [9:0]    ld_addr = '0;
  logic [15:0]   ld_data = '0;
  logic [OW-1:0] ctrl_words;
  logic          load_err;

  int checks = 0;
  int errors = 0;

  logic [14:0] m_line [32];
  logic [CW-1:0] m_slot [NA][8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgx_ctrl_expander i_cfgx_ctrl_expander (
    .clk(clk), .rst(rst), .run(run), .sel(sel), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data), .ctrl_words(ctrl_words),
    .load_err(load_err)
  );

  function automatic logic [OW-1:0] expect_out(input logic [4:0] s);
    logic [OW-1:0] v;
    v = '0;
    for (int k = 0; k < NA; k++) v[k*CW +: CW] = m_slot[k][m_line[s][k*3 +: 3]];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] region, input logic [6:0] off, input logic [15:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = {region, off}; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_line(input int e, input logic [15:0] d);
    wr(3'd0, 7'(e), d);
    if (!run) m_line[e] = d[14:0];
  endtask

  task automatic load_slot(input int alu, input int e, input logic [CW-1:0] v,
                           input logic [10:0] junk);
    wr(3'(alu + 1), {2'b00, 3'(e), 2'd0}, v[15:0]);
    wr(3'(alu + 1), {2'b00, 3'(e), 2'd1}, v[31:16]);
    wr(3'(alu + 1), {2'b00, 3'(e), 2'd2}, {junk, v[36:32]});
    if (!run) m_slot[alu][e] = v;
  endtask

  task automatic check_sel(input logic [4:0] s, input string req);
    @(negedge clk);
    sel = s;
    @(negedge clk);
    chk(ctrl_words === expect_out(s), req, ctrl_words, expect_out(s));
  endtask

  task automatic t_reset;
    chk(ctrl_words === '0, "R1 output after reset", ctrl_words, '0);
    chk(load_err === 1'b0, "R1 error flag after reset", OW'(load_err), '0);
    check_sel(5'd0, "R1 line 0 empty");
    check_sel(5'd31, "R1 line 31 empty");
  endtask

  task automatic t_basic;
    for (int a = 0; a < NA; a++)
      for (int e = 0; e < 8; e++)
        load_slot(a, e, {5'(a * 8 + e), 16'(16'hA000 + a * 256 + e * 17), 16'(e * 4099 + a)}, 11'h000);
    load_line(0, 16'h0000);
    load_line(3, {1'b0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3});
    load_line(17, {1'b1, 3'd1, 3'd3, 3'd5, 3'd7, 3'd2});
    load_line(31, 16'h7FFF);
    check_sel(5'd3, "R2 R4 line 3 mixed slots");
    check_sel(5'd17, "R3 line 17 bit 15 ignored");
    check_sel(5'd31, "R2 line 31 all slot 7");
    check_sel(5'd0, "R6 line 0 all slot 0");
  endtask

  task automatic t_upper_ignored;
    load_slot(4, 7, 37'h1F_DEAD_BEEF, 11'h7FF);
    check_sel(5'd31, "R4 upper 11 bits of word 2 ignored");
    load_slot(2, 7, 37'h0A_1234_5678, 11'h555);
    check_sel(5'd31, "R6 only ALU 2 slot changed");
  endtask

  task automatic t_staging;
    wr(3'd3, {2'b00, 3'd5, 2'd0}, 16'hCAFE);
    wr(3'd3, {2'b00, 3'd5, 2'd1}, 16'hF00D);
    check_sel(5'd3, "R5 slot unchanged before word 2");
    wr(3'd3, {2'b00, 3'd5, 2'd2}, 16'h0013);
    m_slot[2][5] = {5'h13, 16'hF00D, 16'hCAFE};
    check_sel(5'd3, "R5 slot committed by word 2");
  endtask

  task automatic t_ignored;
    wr(3'd6, 7'd3, 16'hFFFF);
    wr(3'd7, 7'd17, 16'h1234);
    wr(3'd1, {2'b00, 3'd7, 2'd3}, 16'hFFFF);
    check_sel(5'd3, "R9 line 3 after ignored loads");
    check_sel(5'd31, "R9 line 31 after ignored loads");
    chk(load_err === 1'b0, "R9 no error from ignored loads", OW'(load_err), '0);
  endtask

  task automatic t_run;
    @(negedge clk); run = 1'b1;
    load_line(3, 16'h0000);
    chk(load_err === 1'b1, "R7 error set by load while running", OW'(load_err), OW'(1));
    load_slot(0, 3, 37'h1F_FFFF_FFFF, 11'h0);
    check_sel(5'd3, "R7 stored state unchanged while running");
    @(negedge clk); run = 1'b0;
    load_line(5, {1'b0, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2});
    check_sel(5'd5, "R8 legal load works after run");
    chk(load_err === 1'b1, "R8 error stays set", OW'(load_err), OW'(1));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(load_err === 1'b0, "R8 error cleared by reset", OW'(load_err), '0);
    chk(ctrl_words === '0, "R1 output cleared by second reset", ctrl_words, '0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_line[i] = '0;
    for (int a = 0; a < NA; a++) for (int e = 0; e < 8; e++) m_slot[a][e] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_upper_ignored();
    t_staging();
    t_ignored();
    t_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule